// File: doc/BRIEF.md
# Residue-Number Arithmetic Unit

This block performs arithmetic on numbers held in residue form over the coprime moduli 8, 7, 5 and 3, which give a dynamic range of 840. Each operand arrives as one packed word that holds four small digits. The block can add, subtract or multiply two operands, or negate the first one. Every digit is handled in its own narrow modular channel. No carry or borrow moves from one digit to another, so the delay through the block is set by the widest channel and not by the word width.

A caller presents both operands and an operation code together with a qualifying strobe. One clock later the registered result appears, with its own strobe. The moduli are declared in a shared package. Digit widths, field positions and the packed word width are all derived from that list, and elaboration rejects a list that is not pairwise coprime.

Top module: `rns_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: A packed word holds the mod-8 digit in bits [10:8], the mod-7 digit in bits [7:5], the mod-5 digit in bits [4:2] and the mod-3 digit in bits [1:0]. A tuple written (d8,d7,d5,d3) follows this order.
- R3: Opcode 2'b00 adds. Each result digit is (a+b) mod m, so (5,5,0,2)+(7,6,4,2) gives (4,4,4,1).
- R4: Opcode 2'b01 subtracts. Each result digit is (a-b) mod m, formed as a plus the modular negation of b.
- R5: Opcode 2'b10 multiplies. Each result digit is (a*b) mod m, so (5,5,0,2)*(7,6,4,2) gives (3,2,0,1).
- R6: Opcode 2'b11 negates operand A. Each digit becomes (m-a) mod m, so (5,0,1,0) gives (3,0,4,0) and a zero digit stays zero. Operand B has no effect on the result.
- R7: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high.
- R8: A clock edge with `in_valid` low leaves `result` unchanged, whatever the opcode and operands are.
- R9: No carry crosses between digits. The mod-8 digit wraps as 3-bit arithmetic, so 7+1 gives 0 there while the other digits are unaffected, and a wrap in a lower digit never changes a higher one.
- R10: When every input digit is below its modulus, every result digit is below its modulus. Input digits at or above their modulus give an undefined result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are sampled on this cycle |
| op | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 negate A |
| opa | input | 11 | Operand A, packed residue word |
| opb | input | 11 | Operand B, packed residue word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 11 | Registered packed residue result |

## Verification
On every clock, the assertions check the one-cycle strobe timing and that the result holds between strobes. They also check the algebraic identities that need no reference model: adding zero returns A, subtracting an operand from itself gives zero, multiplying by zero gives zero, negating zero gives zero, and every result digit stays in range. The specific digit values come only from the bench's reference model. That covers the worked addition, multiplication and negation examples, the mod-8 wraparound with no carry into neighbouring digits, and that operand B is ignored under negation. The model computes these with plain integer remainders and compares them on every cycle across directed and random traffic.

// File: rtl/rns_pkg.sv
`timescale 1ns/1ps
package rns_pkg;

   localparam int NCH = 4;
   // index 0 is the most significant field of the packed word
   localparam int MODS [NCH] = '{8, 7, 5, 3};

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_NEG = 2'b11
   } rns_op_e;

   function automatic int dig_w(input int m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

   function automatic int dig_lsb(input int idx);
      int s;
      s = 0;
      for (int j = idx + 1; j < NCH; j++) s += dig_w(MODS[j]);
      return s;
   endfunction

   function automatic int word_w();
      int s;
      s = 0;
      for (int j = 0; j < NCH; j++) s += dig_w(MODS[j]);
      return s;
   endfunction

   localparam int WORD_W = word_w();

   function automatic int gcd(input int x, input int y);
      int p, q, t;
      p = x;
      q = y;
      while (q != 0) begin
         t = p % q;
         p = q;
         q = t;
      end
      return p;
   endfunction

   // every digit of w lies below its modulus
   function automatic logic word_ok(input logic [WORD_W-1:0] w);
      logic ok;
      int   d;
      ok = 1'b1;
      for (int j = 0; j < NCH; j++) begin
         d = int'((w >> dig_lsb(j)) & ((1 << dig_w(MODS[j])) - 1));
         if (d >= MODS[j]) ok = 1'b0;
      end
      return ok;
   endfunction

endpackage

// File: rtl/rns_mod_add.sv
`timescale 1ns/1ps
module rns_mod_add #(
   parameter  int M = 7,
   localparam int W = (M <= 2) ? 1 : $clog2(M)
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);
   localparam bit POW2 = ((1 << W) == M);

   generate
      if (POW2) begin : g_wrap
         // power-of-two modulus: natural truncation is the reduction
         assign s = a + b;
      end else begin : g_fold
         logic [W:0] raw;
         assign raw = {1'b0, a} + {1'b0, b};
         assign s   = (raw >= (W+1)'(M)) ? W'(raw - (W+1)'(M)) : raw[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rns_chan.sv
`timescale 1ns/1ps
module rns_chan
   import rns_pkg::*;
#(
   parameter  int M = 7,
   localparam int W = (M <= 2) ? 1 : $clog2(M)
) (
   input  rns_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] r
);
   localparam bit POW2 = ((1 << W) == M);

   logic [W-1:0]   neg_a, neg_b, addend, sum, mul_r;
   logic [2*W-1:0] prod;

   assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

   generate
      if (POW2) begin : g_p2
         assign neg_a = W'(0) - a;
         assign neg_b = W'(0) - b;
         assign mul_r = prod[W-1:0];
      end else begin : g_gen
         assign neg_a = (a == '0) ? '0 : W'(M) - a;
         assign neg_b = (b == '0) ? '0 : W'(M) - b;
         assign mul_r = W'(prod % (2*W)'(M));
      end
   endgenerate

   assign addend = (op == OP_SUB) ? neg_b : b;

   rns_mod_add #(.M(M)) u_add (
      .a (a),
      .b (addend),
      .s (sum)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: r = sum;
         OP_MUL:         r = mul_r;
         default:        r = neg_a;
      endcase
   end

   // R10: in-range digits produce an in-range digit
   always_comb begin
      if ((int'(a) < M) && (int'(b) < M))
         a_r10_digit_range : assert (int'(r) < M)
            else $error("digit out of range for modulus %0d", M);
   end
endmodule

// File: rtl/rns_alu.sv
`timescale 1ns/1ps
module rns_alu
   import rns_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [1:0]            op,
   input  logic [WORD_W-1:0]     opa,
   input  logic [WORD_W-1:0]     opb,
   output logic                  out_valid,
   output logic [WORD_W-1:0]     result
);
   logic [WORD_W-1:0] nxt;
   rns_op_e           op_e;

   assign op_e = rns_op_e'(op);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam int CM = MODS[i];
         localparam int CW = dig_w(CM);
         localparam int CL = dig_lsb(i);

         if (CM < 2) begin : g_bad_mod
            $error("modulus %0d below 2", CM);
         end
         for (genvar j = i + 1; j < NCH; j++) begin : g_cop
            if (gcd(CM, MODS[j]) != 1) begin : g_bad_pair
               $error("moduli %0d and %0d share a factor", CM, MODS[j]);
            end
         end

         rns_chan #(.M(CM)) u_ch (
            .op (op_e),
            .a  (opa[CL +: CW]),
            .b  (opb[CL +: CW]),
            .r  (nxt[CL +: CW])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

   // R7: strobe follows the input strobe by one cycle
   a_r7_valid_on : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r7_valid_off : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8: no update without a strobe
   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R3: adding zero returns A
   a_r3_add_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b00 && opb == '0 && word_ok(opa)) |=> result == $past(opa));

   // R4: A minus A is zero
   a_r4_sub_self : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b01 && opa == opb && word_ok(opa)) |=> result == '0);

   // R5: multiply by zero is zero
   a_r5_mul_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b10 && opb == '0 && word_ok(opa)) |=> result == '0);

   // R6: negating zero is zero
   a_r6_neg_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b11 && opa == '0) |=> result == '0);

   // R10: range preserved at the output register
   a_r10_word_range : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && word_ok(opa) && word_ok(opb)) |=> word_ok(result));
endmodule

// File: tb/tb_rns_alu.sv
`timescale 1ns/1ps
module tb_rns_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [10:0] opa = '0;
   logic [10:0] opb = '0;
   logic        out_valid;
   logic [10:0] result;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   logic        exp_v;
   logic [10:0] exp_r;

   always #2.5 clk = ~clk;

   rns_alu dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result)
   );

   // field layout from R2: mod8 [10:8], mod7 [7:5], mod5 [4:2], mod3 [1:0]
   function automatic int modv(input int i);
      case (i)
         0: return 8;
         1: return 7;
         2: return 5;
         default: return 3;
      endcase
   endfunction

   function automatic int getd(input logic [10:0] w, input int i);
      case (i)
         0: return int'(w[10:8]);
         1: return int'(w[7:5]);
         2: return int'(w[4:2]);
         default: return int'(w[1:0]);
      endcase
   endfunction

   function automatic logic [10:0] pk(input int d8, input int d7, input int d5, input int d3);
      logic [2:0] x8, x7, x5;
      logic [1:0] x3;
      x8 = 3'(d8);
      x7 = 3'(d7);
      x5 = 3'(d5);
      x3 = 2'(d3);
      return {x8, x7, x5, x3};
   endfunction

   function automatic logic [10:0] model(input logic [1:0] o, input logic [10:0] a,
                                         input logic [10:0] b);
      int r [4];
      int m, x, y;
      for (int i = 0; i < 4; i++) begin
         m = modv(i);
         x = getd(a, i);
         y = getd(b, i);
         case (o)
            2'b00: r[i] = (x + y) % m;
            2'b01: r[i] = (x - y + m) % m;
            2'b10: r[i] = (x * y) % m;
            default: r[i] = (m - x) % m;
         endcase
      end
      return pk(r[0], r[1], r[2], r[3]);
   endfunction

   function automatic bit in_range(input logic [10:0] w);
      for (int i = 0; i < 4; i++)
         if (getd(w, i) >= modv(i)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [10:0] rand_word();
      return pk(int'($urandom_range(7)), int'($urandom_range(6)),
                int'($urandom_range(4)), int'($urandom_range(2)));
   endfunction

   task automatic check(input string tag, input logic ev, input logic [10:0] er);
      checks++;
      if (out_valid !== ev || result !== er) begin
         errors++;
         $display("FAIL %s: out_valid=%0b result=%03h expected out_valid=%0b result=%03h",
                  tag, out_valid, result, ev, er);
      end
   endtask

   // apply one cycle of stimulus, update the model at the edge, check after it
   task automatic step(input logic v, input logic [1:0] o, input logic [10:0] a,
                       input logic [10:0] b, input string tag);
      in_valid = v;
      op       = o;
      opa      = a;
      opb      = b;
      @(posedge clk);
      @(negedge clk);
      exp_v = v;
      if (v) exp_r = model(o, a, b);
      check(tag, exp_v, exp_r);
   endtask

   function automatic string op_tag(input logic [1:0] o);
      case (o)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      exp_v = 1'b0;
      exp_r = '0;
      repeat (3) @(negedge clk);
      check("R1", 1'b0, 11'h000);            // R1 during reset
      rst_n = 1'b1;
      step(1'b0, 2'b00, '0, '0, "R1");       // R1 first cycle after reset

      // R3 / R2 worked example
      step(1'b1, 2'b00, pk(5,5,0,2), pk(7,6,4,2), "R3");
      check("R3", 1'b1, pk(4,4,4,1));
      // R5 worked example
      step(1'b1, 2'b10, pk(5,5,0,2), pk(7,6,4,2), "R5");
      check("R5", 1'b1, pk(3,2,0,1));
      // R6 worked example, B set to junk that must be ignored
      step(1'b1, 2'b11, pk(5,0,1,0), pk(7,6,4,2), "R6");
      check("R6", 1'b1, pk(3,0,4,0));
      step(1'b1, 2'b11, pk(5,0,1,0), pk(0,0,0,0), "R6");
      check("R6", 1'b1, pk(3,0,4,0));
      // R4: small minus large wraps inside each modulus
      step(1'b1, 2'b01, pk(1,2,0,0), pk(3,5,4,2), "R4");
      check("R4", 1'b1, pk(6,4,1,1));
      // R9: mod-8 wrap stays in its field
      step(1'b1, 2'b00, pk(7,0,0,0), pk(1,0,0,0), "R9");
      check("R9", 1'b1, pk(0,0,0,0));
      // R9: every lower channel wraps, no carry into higher fields
      step(1'b1, 2'b00, pk(0,6,4,2), pk(0,1,1,1), "R9");
      check("R9", 1'b1, pk(0,0,0,0));
      // R9: multiply overflow in mod-8 alone
      step(1'b1, 2'b10, pk(7,1,1,1), pk(7,1,1,1), "R9");
      check("R9", 1'b1, pk(1,1,1,1));
      // R8: hold with changing inputs
      step(1'b0, 2'b10, pk(3,3,3,1), pk(2,2,2,2), "R8");
      check("R8", 1'b0, pk(1,1,1,1));
      step(1'b0, 2'b11, pk(6,6,4,2), pk(6,6,4,2), "R8");
      // R7: back-to-back strobes
      step(1'b1, 2'b01, pk(4,4,4,1), pk(4,4,4,1), "R7");
      step(1'b1, 2'b00, pk(4,4,4,1), pk(0,0,0,0), "R7");

      // random traffic, model compared every cycle
      for (int n = 0; n < 600; n++) begin
         logic        v;
         logic [1:0]  o;
         logic [10:0] a, b;
         v = ($urandom_range(3) != 0);
         o = 2'($urandom_range(3));
         a = rand_word();
         b = rand_word();
         step(v, o, a, b, v ? op_tag(o) : "R8");
         checks++;
         if (!in_range(result)) begin   // R10
            errors++;
            $display("FAIL R10: result=%03h expected all digits in range", result);
         end
      end

      // R1: reset mid-stream clears state
      rst_n = 1'b0;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exp_v = 1'b0;
      exp_r = '0;
      check("R1", 1'b0, 11'h000);
      rst_n = 1'b1;
      step(1'b0, 2'b00, '0, '0, "R1");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule